// File: doc/BRIEF.md
# Count-to-Limit Interval Timer

This block is a single interval timer with a small register interface. Software selects one of three registers by a two-bit select code: control, count and limit. While the run bit in control is set, the count rises by one on every clock. When the count reaches the limit, the next advance loads zero and a sticky pending flag is raised. The interrupt line is a level: it is high while the pending flag and the interrupt-enable bit are both set.

A write to the control register is an acknowledge and a re-arm in the same access. It always clears the pending flag, and it loads only the enable and run bits from the write data. Writing the count restarts the period from any value, and writing zero starts a fresh period. Writing the limit sets the period length. With the limit left at all ones, which is its reset value, the block acts as a free-running 32-bit counter that wraps without gaps. A system can place two instances side by side: one armed for periodic or single-shot events, and one left free-running as a time base.

Top module: `tmr_count_limit`

## Requirements
- R1: After reset the count reads 0, the limit reads all ones, the control register reads 0, and `irq` is low.
- R2: `irq` is high exactly while the pending flag and the interrupt-enable bit are both set. It is a level that stays up until one of them is cleared.
- R3: The count changes only while the run bit (control bit 1) is set, or when the count register is written. While the run bit is clear, the count holds its value.
- R4: If the run bit is set and the count equals the limit, the pending flag (control bit 3) is set. This happens whether or not interrupts are enabled. The flag then stays set until a control write clears it.
- R5: Any control write clears the pending flag. It loads interrupt-enable from data bit 0 and run from data bit 1 and ignores all other data bits. Control reads return enable at bit 0, run at bit 1, pending at bit 3, and zero elsewhere.
- R6: A count write loads the written value on the next clock edge and takes priority over counting. A count written that way causes no pending event in that cycle. Writing 0 restarts the period from zero.
- R7: If the run bit is set and the count equals the limit, the next clock edge loads zero into the count.
- R8: With the limit at all ones, the count passes through all ones and then wraps to zero, raising the pending flag.
- R9: If a limit-reached event and a control write fall in the same cycle, the pending flag ends up set.
- R10: Select codes: 0 is control, 1 is count, 2 is limit. Code 3 reads as zero, and writes to code 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Register select code for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select code for the read |
| rd_data | output | 32 | Combinational read data for `rd_sel` |
| irq | output | 1 | Level interrupt request |

## Verification
The count register is readable at any time, so a fault in the advance or wrap logic shows up as a wrong count value on the next clock. Because the bench knows the cycle of every write, it can predict that value exactly. A pending flag that is set late, lost, or cleared by the wrong event appears at the port in two ways: in control bit 3 of the cycle right after the limit-reached edge, and on `irq` when enable is set. The stickiness checks wait several cycles, and the same-cycle acknowledge case is driven edge on edge. Together they expose faults in write priority that a slower stimulus would hide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_LIMIT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_IE_BIT   = 0;
  localparam int unsigned CTRL_RUN_BIT  = 1;
  localparam int unsigned CTRL_PEND_BIT = 3;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_wr,
  input  logic             lim_wr,
  input  logic [WIDTH-1:0] wr_val,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] limit,
  output logic             hit_evt
);
  logic [WIDTH-1:0] count_d, limit_d;
  logic             at_limit;
  logic             count_en;

  assign at_limit = (count == limit);
  assign hit_evt  = run & at_limit & ~cnt_wr;
  assign count_en = cnt_wr | run;

  always_comb begin
    count_d = count;
    if (cnt_wr)        count_d = wr_val;
    else if (at_limit) count_d = '0;
    else               count_d = count + 1'b1;
  end

  always_comb begin
    limit_d = limit;
    if (lim_wr) limit_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit <= '1;
    else        limit <= limit_d;
  end

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count)); // R3

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr && count == limit) |=> (count == '0)); // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count == $past(wr_val))); // R6
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_ie,
  input  logic wr_run,
  input  logic hit_evt,
  output logic ie,
  output logic run,
  output logic pend
);
  logic ie_d, run_d, pend_d;

  always_comb begin
    ie_d   = ctrl_wr ? wr_ie  : ie;
    run_d  = ctrl_wr ? wr_run : run;
    pend_d = pend;
    if (ctrl_wr) pend_d = 1'b0;
    if (hit_evt) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      run  <= 1'b0;
      pend <= 1'b0;
    end else begin
      ie   <= ie_d;
      run  <= run_d;
      pend <= pend_d;
    end
  end

  AST_PEND_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> pend); // R4

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ctrl_wr) |=> pend); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !hit_evt) |=> !pend); // R5
endmodule

// File: rtl/tmr_count_limit.sv
module tmr_count_limit
  import tmr_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [WIDTH-1:0] rd_data,
  output logic             irq
);
  logic             rst_sync_n;
  logic             ctrl_wr, cnt_wr, lim_wr;
  logic             ie, run, pend, hit_evt;
  logic [WIDTH-1:0] count, limit, ctrl_view;

  tmr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
  assign cnt_wr  = wr_en && (wr_sel == SEL_COUNT);
  assign lim_wr  = wr_en && (wr_sel == SEL_LIMIT);

  tmr_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .cnt_wr(cnt_wr),
    .lim_wr(lim_wr), .wr_val(wr_data), .count(count), .limit(limit),
    .hit_evt(hit_evt)
  );

  tmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .ctrl_wr(ctrl_wr),
    .wr_ie(wr_data[CTRL_IE_BIT]), .wr_run(wr_data[CTRL_RUN_BIT]),
    .hit_evt(hit_evt), .ie(ie), .run(run), .pend(pend)
  );

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_IE_BIT]   = ie;
    ctrl_view[CTRL_RUN_BIT]  = run;
    ctrl_view[CTRL_PEND_BIT] = pend;
  end

  always_comb begin
    case (rd_sel)
      SEL_CTRL:  rd_data = ctrl_view;
      SEL_COUNT: rd_data = count;
      SEL_LIMIT: rd_data = limit;
      default:   rd_data = '0;
    endcase
  end

  assign irq = pend & ie;

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq && !ctrl_wr) |=> irq); // R2

  AST_NONE_SEL_INERT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_sel == SEL_NONE) |=> ($stable(limit) && $stable(ie))); // R10
endmodule

// File: tb/tb_tmr_count_limit.sv
module tb_tmr_count_limit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_LIM = 2'd2, A_NONE = 2'd3;

  always #10 clk = ~clk;

  tmr_count_limit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CNT, v);  chk("R1 count", v, 32'h0);
    rd(A_LIM, v);  chk("R1 limit", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_halted;
    logic [31:0] v;
    wr(A_CNT, 32'd5);
    idle(3);
    rd(A_CNT, v); chk("R3 halted hold", v, 32'd5);
  endtask

  task automatic t_wrap_no_ie;
    logic [31:0] v;
    wr(A_LIM, 32'd3); wr(A_CNT, 32'd0); wr(A_CTRL, 32'h2);
    rd(A_CNT, v); chk("R3 start", v, 32'd0);
    for (int i = 1; i <= 3; i++) begin
      idle(1); rd(A_CNT, v); chk("R3 advance", v, i);
    end
    idle(1);
    rd(A_CNT, v);  chk("R7 wrap zero", v, 32'd0);
    rd(A_CTRL, v); chk("R4 pend no ie", v, 32'hA);
    chk("R2 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R5 ack clears", v, 32'h0);
    idle(2);
    rd(A_CNT, v);  chk("R3 stopped", v, 32'd1);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(A_LIM, 32'd2); wr(A_CNT, 32'd0); wr(A_CTRL, 32'h3);
    idle(3);
    rd(A_CNT, v); chk("R7 wrap", v, 32'd0);
    chk("R2 irq high", {31'b0, irq}, 32'h1);
    idle(4);
    chk("R4 sticky irq", {31'b0, irq}, 32'h1);
    rd(A_CTRL, v); chk("R4 sticky pend", v, 32'hB);
    wr(A_CTRL, 32'h1);
    chk("R2 irq after ack", {31'b0, irq}, 32'h0);
    rd(A_CTRL, v); chk("R5 ack keeps ie", v, 32'h1);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_LIM, 32'd3); wr(A_CNT, 32'd3);
    wr(A_CTRL, 32'h3);
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, v); chk("R9 event beats ack", v, 32'hB);
    rd(A_CNT, v);  chk("R9 count wrapped", v, 32'd0);
    chk("R9 irq", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_load;
    logic [31:0] v;
    wr(A_LIM, 32'd10); wr(A_CNT, 32'd0); wr(A_CTRL, 32'h2);
    idle(2);
    rd(A_CNT, v); chk("R3 run", v, 32'd2);
    wr(A_CNT, 32'd7);
    rd(A_CNT, v); chk("R6 load wins", v, 32'd7);
    idle(1);
    rd(A_CNT, v); chk("R6 resume", v, 32'd8);
    wr(A_CNT, 32'd0);
    rd(A_CNT, v); chk("R6 restart zero", v, 32'd0);
    idle(1);
    rd(A_CNT, v); chk("R6 after restart", v, 32'd1);
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R6 no pend", v, 32'h0);
  endtask

  task automatic t_free_run;
    logic [31:0] v;
    wr(A_LIM, 32'hFFFF_FFFF); wr(A_CNT, 32'hFFFF_FFFE); wr(A_CTRL, 32'h2);
    rd(A_CNT, v); chk("R8 start", v, 32'hFFFF_FFFE);
    idle(1);
    rd(A_CNT, v);  chk("R8 max", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R8 no pend yet", v, 32'h2);
    idle(1);
    rd(A_CNT, v);  chk("R8 wrap", v, 32'h0);
    rd(A_CTRL, v); chk("R8 pend", v, 32'hA);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_masks;
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFF_FFF4);
    rd(A_CTRL, v); chk("R5 other bits ignored", v, 32'h0);
    wr(A_CNT, 32'd100);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R10 none ctrl", v, 32'h0);
    rd(A_CNT, v);  chk("R10 none count", v, 32'd100);
    rd(A_LIM, v);  chk("R10 none limit", v, 32'hFFFF_FFFF);
    rd(A_NONE, v); chk("R10 none reads zero", v, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R5 enable and run only", v, 32'h3);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_halted();
    t_wrap_no_ie();
    t_irq();
    t_same_cycle();
    t_load();
    t_free_run();
    t_masks();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule